// File: doc/BRIEF.md
# Coalesced Interrupt Status Controller

This block collects hardware events into a host-visible interrupt status word and drives one level-sensitive interrupt line towards the host. Events arrive as single-cycle pulses. Some go straight into the main status word. Others go into a secondary status word owned by the DMA engines, with per-channel receive, transmit, error and urgent-receive bits. Three main-status bits are not stored. They are summaries, computed from the secondary word. Software acknowledges a bit by writing 1 to it. An enable mask selects which main-status bits may reach the interrupt line.

The host line is not raised the moment an event appears. A coalescing timer, programmed in 32-microsecond units, holds it off so that bursts of events cost the host a single interrupt. A zero timer value removes the delay. An urgent receive event in the secondary word also skips the delay. A separate periodic byte makes the block post a periodic receive flag at a fixed interval of ticks. A clock divider, set by a parameter, derives the 32-microsecond tick, so a testbench can shorten it.

Top module: `irqCoalTop`

## Requirements
- R1: After reset the interrupt line is low. Main status, secondary status, mask and the periodic byte read 0. The coalescing value reads 0x40 (2048 µs).
- R2: Register addresses on `busAddr`. 0 is main status, 1 is the enable mask, 2 is secondary status, 3 is the coalescing value (bits 7:0) and 4 is the periodic byte (bits 7:0). Reads are combinational. Any other address reads 0.
- R3: Main and secondary status bits are set by events and cleared only by writing 1 to them. Writing 0 leaves them unchanged. An event in the same cycle as a clear of that bit leaves the bit set.
- R4: Main bit 31 reads as the OR of secondary bits 30, 17 and 16. Main bit 29 reflects secondary bit 31. Main bit 27 is the OR of secondary bits 1 and 0. Direct events at main bits 31, 29 and 27 are ignored.
- R5: A main status bit whose mask bit is 0 is still recorded but never raises the interrupt line.
- R6: Let N be a nonzero coalescing value and T the clocks per tick. With the line idle, an enabled event sampled at clock edge e0 raises the line no earlier than edge e0+(N-1)·T+2 and no later than edge e0+N·T+1.
- R7: With a coalescing value of 0, an enabled event sampled at edge e0 raises the line after edge e0+1.
- R8: A secondary bit 30 event, with mask bit 31 set, raises the line after the next edge whatever the coalescing value, including during a wait that is already running.
- R9: The line stays high while any enabled main bit is set. It falls after the edge that follows the write clearing the last one.
- R10: A nonzero periodic byte P sets main bit 28 once every P ticks. A value of 0 stops it.
- R11: One tick occurs every TICK_CYCLES clocks. The default of 1600 gives 32 µs at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtMain | input | 32 | Single-cycle event pulses for main status |
| evtDma | input | 32 | Single-cycle event pulses for secondary status |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| hostIrq | output | 1 | Level interrupt to the host |

## Verification
The hardest state to reach from the ports is an urgent receive event that arrives while a long coalescing wait is already running. The event must cut the wait short, and it must do so without a second event re-arming the timer. The bench first posts an ordinary receive-channel event under the default 0x40 value and confirms that the line is still low several edges later. It then pulses secondary bit 30 and expects the line one edge after that. The coalescing window is checked at both of its ends with a shortened tick, because the phase of the free-running divider is unknown.

// File: rtl/irqCoalPkg.sv
package irqCoalPkg;
  localparam int DATA_W     = 32;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_MAIN   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_DMA    = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_COAL   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_PERIOD = 3'd4;

  // main status positions
  localparam int BIT_RX_SUM   = 31;
  localparam int BIT_ERR_SUM  = 29;
  localparam int BIT_PERIODIC = 28;
  localparam int BIT_TX_SUM   = 27;

  // secondary status positions
  localparam int DMA_ERR   = 31;
  localparam int DMA_HIPRI = 30;
  localparam int DMA_RX1   = 17;
  localparam int DMA_RX0   = 16;
  localparam int DMA_TX1   = 1;
  localparam int DMA_TX0   = 0;

  localparam logic [DATA_W-1:0] SUMMARY_MASK =
    (DATA_W'(1) << BIT_RX_SUM) | (DATA_W'(1) << BIT_ERR_SUM) | (DATA_W'(1) << BIT_TX_SUM);

  typedef struct packed {
    logic loadTimer;
    logic runTimer;
  } coalStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIRE = 2'd2
  } irqStateT;
endpackage

// File: rtl/coalTickDiv.sv
module coalTickDiv #(
  parameter int TICK_CYCLES = 1600
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  generate
    if (TICK_CYCLES < 2) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(TICK_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)              divCnt <= '0;
        else if (divCnt == LAST) divCnt <= '0;
        else                    divCnt <= divCnt + CW'(1);
      end
      assign tick = (divCnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/coalDatapath.sv
module coalDatapath
  import irqCoalPkg::*;
#(
  parameter int               COAL_W     = 8,
  parameter logic [COAL_W-1:0] COAL_RESET = 8'h40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  coalStrobeT            strobe,
  input  logic [DATA_W-1:0]     evtMain,
  input  logic [DATA_W-1:0]     evtDma,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  enabledPending,
  output logic                  hiPrioPending,
  output logic                  coalZero,
  output logic                  timerDone
);
  logic [DATA_W-1:0] mainStore, dmaStat, maskReg, mainView, rollup, mainSet;
  logic [COAL_W-1:0] coalReg, periodReg, timerCnt, periodCnt;
  logic wrMain, wrMask, wrDma, wrCoal, wrPeriod, periodOn, periodHit;

  assign wrMain   = busWrEn && (busAddr == ADDR_MAIN);
  assign wrMask   = busWrEn && (busAddr == ADDR_MASK);
  assign wrDma    = busWrEn && (busAddr == ADDR_DMA);
  assign wrCoal   = busWrEn && (busAddr == ADDR_COAL);
  assign wrPeriod = busWrEn && (busAddr == ADDR_PERIOD);

  // summary bits derived from the secondary word
  always_comb begin
    rollup = '0;
    rollup[BIT_RX_SUM]  = dmaStat[DMA_HIPRI] | dmaStat[DMA_RX1] | dmaStat[DMA_RX0];
    rollup[BIT_ERR_SUM] = dmaStat[DMA_ERR];
    rollup[BIT_TX_SUM]  = dmaStat[DMA_TX1] | dmaStat[DMA_TX0];
  end

  // periodic flag generator
  assign periodOn  = (periodReg != '0);
  assign periodHit = tick && periodOn && (periodCnt == periodReg - COAL_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                 periodCnt <= '0;
    else if (wrPeriod)         periodCnt <= '0;
    else if (tick && periodOn) periodCnt <= periodHit ? '0 : periodCnt + COAL_W'(1);
  end

  assign mainSet = (evtMain & ~SUMMARY_MASK) | (periodHit ? (DATA_W'(1) << BIT_PERIODIC) : '0);

  // write-one-to-clear status; a same-cycle event wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainStore <= '0;
      dmaStat   <= '0;
    end else begin
      mainStore <= (mainStore & ~(wrMain ? busWrData : '0)) | mainSet;
      dmaStat   <= (dmaStat & ~(wrDma ? busWrData : '0)) | evtDma;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      coalReg   <= COAL_RESET;
      periodReg <= '0;
    end else begin
      if (wrMask)   maskReg   <= busWrData;
      if (wrCoal)   coalReg   <= busWrData[COAL_W-1:0];
      if (wrPeriod) periodReg <= busWrData[COAL_W-1:0];
    end
  end

  // coalescing countdown
  always_ff @(posedge clk) begin
    if (!rstN)                 timerCnt <= '0;
    else if (strobe.loadTimer) timerCnt <= coalReg;
    else if (strobe.runTimer && tick && timerCnt != '0) timerCnt <= timerCnt - COAL_W'(1);
  end

  assign mainView       = mainStore | rollup;
  assign enabledPending = |(mainView & maskReg);
  assign hiPrioPending  = dmaStat[DMA_HIPRI] & maskReg[BIT_RX_SUM];
  assign coalZero       = (coalReg == '0);
  assign timerDone      = tick && (timerCnt <= COAL_W'(1));

  always_comb begin
    unique case (busAddr)
      ADDR_MAIN:   busRdData = mainView;
      ADDR_MASK:   busRdData = maskReg;
      ADDR_DMA:    busRdData = dmaStat;
      ADDR_COAL:   busRdData = DATA_W'(coalReg);
      ADDR_PERIOD: busRdData = DATA_W'(periodReg);
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/coalCtrl.sv
module coalCtrl
  import irqCoalPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enabledPending,
  input  logic       hiPrioPending,
  input  logic       coalZero,
  input  logic       timerDone,
  output coalStrobeT strobe,
  output logic       hostIrq
);
  irqStateT state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe.loadTimer = 1'b0;
    strobe.runTimer  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enabledPending) begin
          if (coalZero || hiPrioPending) stateNext = ST_FIRE;
          else begin
            stateNext        = ST_WAIT;
            strobe.loadTimer = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        strobe.runTimer = 1'b1;
        if (!enabledPending) stateNext = ST_IDLE;
        else if (coalZero || hiPrioPending || timerDone) stateNext = ST_FIRE;
      end
      ST_FIRE: begin
        if (!enabledPending) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hostIrq = (state == ST_FIRE);
endmodule

// File: rtl/irqCoalTop.sv
module irqCoalTop
  import irqCoalPkg::*;
#(
  parameter int               TICK_CYCLES = 1600,
  parameter int               COAL_W      = 8,
  parameter logic [COAL_W-1:0] COAL_RESET  = 8'h40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     evtMain,
  input  logic [DATA_W-1:0]     evtDma,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  hostIrq
);
  logic       tick, enabledPending, hiPrioPending, coalZero, timerDone;
  coalStrobeT strobe;

  coalTickDiv #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  coalDatapath #(.COAL_W(COAL_W), .COAL_RESET(COAL_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .evtMain(evtMain), .evtDma(evtDma),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .enabledPending(enabledPending), .hiPrioPending(hiPrioPending),
    .coalZero(coalZero), .timerDone(timerDone)
  );

  coalCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .enabledPending(enabledPending), .hiPrioPending(hiPrioPending),
    .coalZero(coalZero), .timerDone(timerDone),
    .strobe(strobe), .hostIrq(hostIrq)
  );
endmodule

// File: rtl/coalChecker.sv
module coalChecker
  import irqCoalPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0]     busRdData,
  input logic                  hostIrq,
  input logic                  enabledPending,
  input logic                  hiPrioPending,
  input logic                  coalZero
);
  // R3: with no write to main status, no stored bit falls between reads
  assert_w1c_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_MAIN && !busWrEn) |=>
      (busAddr != ADDR_MAIN || ((($past(busRdData)) & ~busRdData & ~SUMMARY_MASK) == '0)));

  // R5: nothing enabled pending means the line is low next cycle
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enabledPending |=> !hostIrq);

  // R7: zero coalescing value fires after one edge
  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enabledPending && coalZero) |=> hostIrq);

  // R8: urgent receive bypasses the timer
  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rstN)
    hiPrioPending |=> hostIrq);

  // R9: line holds while work remains
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq && enabledPending) |=> hostIrq);

  // R6: the line only rises with a cause behind it
  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(enabledPending));
endmodule

bind irqCoalTop coalChecker u_coalChecker (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busRdData(busRdData),
  .hostIrq(hostIrq), .enabledPending(enabledPending), .hiPrioPending(hiPrioPending),
  .coalZero(coalZero)
);

// File: tb/test_irqCoalTop.sv
module test_irqCoalTop;
  import irqCoalPkg::*;

  localparam int TICK = 8;

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [DATA_W-1:0]     evtMain, evtDma, busWrData, busRdData;
  logic                  busWrEn, hostIrq;
  logic [REG_ADDR_W-1:0] busAddr;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irqCoalTop #(.TICK_CYCLES(TICK)) i_irqCoalTop (
    .clk(clk), .rstN(rstN), .evtMain(evtMain), .evtDma(evtDma),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [REG_ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdReg(input logic [REG_ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pulseMain(input logic [31:0] bits);
    @(negedge clk); evtMain = bits;
    @(posedge clk);
    @(negedge clk); evtMain = '0;
  endtask

  task automatic pulseDma(input logic [31:0] bits);
    @(negedge clk); evtDma = bits;
    @(posedge clk);
    @(negedge clk); evtDma = '0;
  endtask

  task automatic cleanup();
    wrReg(ADDR_MASK, 32'h0);
    wrReg(ADDR_DMA, 32'hFFFF_FFFF);
    wrReg(ADDR_MAIN, 32'hFFFF_FFFF);
    waitEdges(2);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1", "irq after reset", {31'd0, hostIrq}, 32'd0);
    rdReg(ADDR_MAIN, v);   check("R1", "main status", v, 32'h0);
    rdReg(ADDR_MASK, v);   check("R1", "mask", v, 32'h0);
    rdReg(ADDR_DMA, v);    check("R1", "secondary status", v, 32'h0);
    rdReg(ADDR_COAL, v);   check("R1", "coalescing default", v, 32'h40);
    rdReg(ADDR_PERIOD, v); check("R1", "periodic byte", v, 32'h0);
    rdReg(3'd5, v);        check("R2", "unmapped address", v, 32'h0);
    wrReg(ADDR_MASK, 32'h0000_0A50);
    rdReg(ADDR_MASK, v);   check("R2", "mask readback", v, 32'h0000_0A50);
    wrReg(ADDR_COAL, 32'h0000_1234);
    rdReg(ADDR_COAL, v);   check("R2", "coal keeps low byte", v, 32'h34);
    wrReg(ADDR_COAL, 32'h40);
    cleanup();
  endtask

  task automatic testW1c();
    logic [31:0] v;
    pulseMain(32'h24);
    rdReg(ADDR_MAIN, v); check("R3", "events recorded", v, 32'h24);
    wrReg(ADDR_MAIN, 32'h0);
    rdReg(ADDR_MAIN, v); check("R3", "write 0 no effect", v, 32'h24);
    wrReg(ADDR_MAIN, 32'h04);
    rdReg(ADDR_MAIN, v); check("R3", "write 1 clears", v, 32'h20);
    // event and clear of the same bit in one cycle
    @(negedge clk);
    evtMain = 32'h20; busWrEn = 1'b1; busAddr = ADDR_MAIN; busWrData = 32'h20;
    @(posedge clk);
    @(negedge clk);
    evtMain = '0; busWrEn = 1'b0; busWrData = '0;
    rdReg(ADDR_MAIN, v); check("R3", "set wins over clear", v, 32'h20);
    pulseDma(32'h0000_0002);
    wrReg(ADDR_DMA, 32'h0);
    rdReg(ADDR_DMA, v); check("R3", "secondary write 0", v, 32'h2);
    wrReg(ADDR_DMA, 32'h2);
    rdReg(ADDR_DMA, v); check("R3", "secondary clear", v, 32'h0);
    cleanup();
  endtask

  task automatic testRollup();
    logic [31:0] v;
    pulseDma(32'h0002_0000);
    rdReg(ADDR_MAIN, v); check("R4", "rx channel 1 summary", v, 32'h8000_0000);
    wrReg(ADDR_DMA, 32'h0002_0000);
    rdReg(ADDR_MAIN, v); check("R4", "summary follows secondary", v, 32'h0);
    pulseDma(32'h0000_0001);
    rdReg(ADDR_MAIN, v); check("R4", "tx channel 0 summary", v, 32'h0800_0000);
    pulseDma(32'h8000_0000);
    rdReg(ADDR_MAIN, v); check("R4", "error summary", v, 32'h2800_0000);
    wrReg(ADDR_DMA, 32'hFFFF_FFFF);
    pulseMain(32'hA800_0000);
    rdReg(ADDR_MAIN, v); check("R4", "direct summary events ignored", v, 32'h0);
    cleanup();
  endtask

  task automatic testMask();
    logic [31:0] v;
    wrReg(ADDR_MASK, 32'h08);
    pulseMain(32'h20);
    waitEdges(40);
    check("R5", "masked bit keeps line low", {31'd0, hostIrq}, 32'd0);
    rdReg(ADDR_MAIN, v); check("R5", "masked bit recorded", v, 32'h20);
    cleanup();
  endtask

  task automatic testCoalesce();
    wrReg(ADDR_COAL, 32'd3);
    wrReg(ADDR_MASK, 32'h10);
    pulseMain(32'h10);
    waitEdges(17);
    check("R6", "held off before window", {31'd0, hostIrq}, 32'd0);
    waitEdges(9);
    check("R6", "raised by end of window", {31'd0, hostIrq}, 32'd1);
    wrReg(ADDR_MASK, 32'h50);
    pulseMain(32'h40);
    wrReg(ADDR_MAIN, 32'h10);
    waitEdges(3);
    check("R9", "held while bit 6 pending", {31'd0, hostIrq}, 32'd1);
    wrReg(ADDR_MAIN, 32'h40);
    check("R9", "still high at clearing edge", {31'd0, hostIrq}, 32'd1);
    waitEdges(1);
    check("R9", "drops one edge later", {31'd0, hostIrq}, 32'd0);
    cleanup();
  endtask

  task automatic testZero();
    wrReg(ADDR_COAL, 32'd0);
    wrReg(ADDR_MASK, 32'h04);
    pulseMain(32'h04);
    check("R7", "low at event edge", {31'd0, hostIrq}, 32'd0);
    waitEdges(1);
    check("R7", "high one edge later", {31'd0, hostIrq}, 32'd1);
    cleanup();
  endtask

  task automatic testHiPrio();
    wrReg(ADDR_COAL, 32'h40);
    wrReg(ADDR_MASK, 32'h8000_0000);
    pulseDma(32'h0001_0000);
    waitEdges(5);
    check("R6", "rx channel 0 is coalesced", {31'd0, hostIrq}, 32'd0);
    pulseDma(32'h4000_0000);
    check("R8", "low at urgent event edge", {31'd0, hostIrq}, 32'd0);
    waitEdges(1);
    check("R8", "urgent event bypasses wait", {31'd0, hostIrq}, 32'd1);
    wrReg(ADDR_DMA, 32'hFFFF_FFFF);
    waitEdges(1);
    check("R9", "drops after secondary cleared", {31'd0, hostIrq}, 32'd0);
    cleanup();
  endtask

  task automatic testPeriodic();
    logic [31:0] v;
    wrReg(ADDR_PERIOD, 32'd2);
    rdReg(ADDR_PERIOD, v); check("R2", "periodic readback", v, 32'd2);
    waitEdges(40);
    rdReg(ADDR_MAIN, v); check("R10", "periodic flag posted", v & 32'h1000_0000, 32'h1000_0000);
    check("R11", "tick drives periodic, line low while masked", {31'd0, hostIrq}, 32'd0);
    wrReg(ADDR_PERIOD, 32'd0);
    wrReg(ADDR_MAIN, 32'h1000_0000);
    waitEdges(100);
    rdReg(ADDR_MAIN, v); check("R10", "periodic off stays clear", v, 32'h0);
    cleanup();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; evtMain = '0; evtDma = '0;
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testW1c();
    testRollup();
    testMask();
    testCoalesce();
    testZero();
    testHiPrio();
    testPeriodic();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule